// File: doc/BRIEF.md
# CAN Receive Frame Queue with Word-Wide Readout

This block is a circular store for received CAN and CAN FD frames. A producer pushes each frame as a stream of 32-bit words. The first word is the format word, with the data length code in bits [3:0]. The second word is the identifier. Two further header words follow, and then the payload words, so the payload starts at byte offset 0x10 of the stored frame.

When the first word of a frame arrives, the block works out the frame's size from the length code. If the frame fits, the block stores it one word per cycle. The frame becomes visible to the reader only after its last word is stored. If it does not fit, the whole frame is dropped and the overrun condition is flagged.

A consumer reads one word per request, in stored order. The block uses a word-count field that it writes into each format word to find where each frame ends, and so keeps a count of the complete frames still pending. It also reports fill state, free space, the read and write byte positions, and a running count of accepted frames. Two one-cycle pulses mark an accepted frame and a dropped frame.

Top module: `canrx_word_fifo`

## Requirements
- R1: The payload size in bytes follows from the length code: codes 0..8 give 0..8 bytes, 9, 10, 11 and 12 give 12, 16, 20 and 24 bytes, and 13, 14 and 15 give 32, 48 and 64 bytes. The stored frame takes 4 + ceil(bytes/4) words, and an accepted frame lowers `free_words` by exactly that number.
- R2: The first word of a frame is stored with bits [15:11] replaced by (frame words − 1). Every other bit of that word, and every later word of the frame, is stored unchanged and in arrival order.
- R3: If the committed fill in words plus the new frame's words exceeds 64, the frame is dropped whole. None of its words are stored, `overrun` becomes 1, and `ovr_irq` pulses for one cycle, in the cycle after the frame's first word.
- R4: When the last word of an accepted frame is stored, `frame_cnt` and `rx_frame_ctr` each rise by one. `rx_irq` is 1 for exactly the one cycle that follows.
- R5: `rd_data` always shows the word at the read position. A request with data present pops that word and advances `rd_ptr` by 4, modulo 256.
- R6: A request while the store is empty returns 0 and changes no pointer, count or flag.
- R7: `frame_cnt` falls by one in the cycle after the last word of a frame is popped, and not before.
- R8: `empty` is 1 exactly when `frame_cnt` is 0. `full` is 1 exactly when the committed fill is 64 words.
- R9: `size_words` is 64 and `free_words` is 64 minus the fill. `wr_ptr` equals `rd_ptr` + 4 × fill, modulo 256.
- R10: `cmd_flush` clears the read position, the fill, the frame-tracking count and `frame_cnt`, and abandons a frame that is partly written. It takes priority over a pop or a write in the same cycle, and it leaves `rx_frame_ctr` and `overrun` as they are.
- R11: `cmd_clr_ovr` clears `overrun`. If a frame is dropped in the same cycle, `overrun` stays 1.
- R12: A word offered without the start flag, while no accepted frame is in progress, is ignored. This covers the remaining words of a dropped or abandoned frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fr_vld | input | 1 | A frame word is offered this cycle |
| fr_sof | input | 1 | The offered word is the first word of a frame |
| fr_word | input | 32 | Offered frame word |
| rd_req | input | 1 | Read request; pops one word if data is present |
| rd_data | output | 32 | Word at the read position, or 0 when empty |
| cmd_flush | input | 1 | Discard all stored and in-progress frames |
| cmd_clr_ovr | input | 1 | Clear the overrun flag |
| empty | output | 1 | No complete frame pending |
| full | output | 1 | Fill equals the store size |
| overrun | output | 1 | Sticky flag: a frame was dropped for lack of space |
| free_words | output | 7 | Free space in words |
| size_words | output | 7 | Store size in words |
| rd_ptr | output | 8 | Read byte position |
| wr_ptr | output | 8 | Byte position where the next frame will start |
| frame_cnt | output | 7 | Complete frames pending |
| rx_frame_ctr | output | 16 | Running count of accepted frames |
| rx_irq | output | 1 | One-cycle pulse per accepted frame |
| ovr_irq | output | 1 | One-cycle pulse per dropped frame |

## Verification
The assertions check several rules on every cycle. The fill never passes the store size. A pending fill always comes with a nonzero frame count. A pop steps the read position by one word, and a request on an empty store leaves that position alone. A flush leaves everything cleared, and a dropped frame sets the overrun flag and ends any frame that was being written.

Only the bench scenarios can show the rest. These are the length-code-to-size mapping, the word-count field written into the stored header, and word-exact data order across the wrap. They also cover the cycle on which the frame count falls at each frame's end, and that a flush in the middle of a frame really resets the tracking for the next one.

// File: rtl/canrx_pkg.sv
package canrx_pkg;
  localparam int HDR_WORDS = 4;
  localparam int CNT_LSB   = 11;
  localparam int CNT_W     = 5;

  // payload bytes for a 4-bit length code
  function automatic logic [6:0] dlc_bytes(input logic [3:0] dlc);
    logic [6:0] b;
    if (dlc <= 4'd8)       b = {3'b000, dlc};
    else if (dlc <= 4'd12) b = 7'd8 + {1'b0, dlc - 4'd8, 2'b00};
    else if (dlc == 4'd13) b = 7'd32;
    else if (dlc == 4'd14) b = 7'd48;
    else                   b = 7'd64;
    return b;
  endfunction

  // words a stored frame occupies: header plus payload rounded up to words
  function automatic logic [CNT_W-1:0] frame_words(input logic [3:0] dlc);
    logic [7:0] padded;
    padded = {1'b0, dlc_bytes(dlc)} + 8'd3;
    return CNT_W'(HDR_WORDS) + CNT_W'(padded >> 2);
  endfunction

  function automatic logic [31:0] put_count(input logic [31:0] w,
                                            input logic [CNT_W-1:0] cnt);
    logic [31:0] r;
    r = w;
    r[CNT_LSB +: CNT_W] = cnt;
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] get_count(input logic [31:0] w);
    return w[CNT_LSB +: CNT_W];
  endfunction
endpackage

// File: rtl/canrx_word_ram.sv
module canrx_word_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/canrx_frame_writer.sv
module canrx_frame_writer
  import canrx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int LW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fr_vld,
  input  logic             fr_sof,
  input  logic [31:0]      fr_word,
  input  logic [AW-1:0]    head_w,
  input  logic [LW-1:0]    level_w,
  output logic             wen,
  output logic [AW-1:0]    waddr,
  output logic [31:0]      wdata,
  output logic             commit,
  output logic [CNT_W-1:0] commit_words,
  output logic             ovr_evt
);
  logic             busy_q;
  logic [AW-1:0]    ptr_q;
  logic [CNT_W-1:0] left_q, tot_q;
  logic [CNT_W-1:0] words_new;
  logic [LW:0]      need;
  logic             sof_evt, fits, accept, body;

  assign words_new = frame_words(fr_word[3:0]);
  assign need      = {1'b0, level_w} + (LW+1)'(words_new);
  assign fits      = need <= (LW+1)'(DEPTH);
  assign sof_evt   = fr_vld && fr_sof && !flush;
  assign accept    = sof_evt && fits;
  assign ovr_evt   = sof_evt && !fits;
  assign body      = fr_vld && !fr_sof && !flush && busy_q;

  assign wen          = accept || body;
  assign waddr        = accept ? head_w : ptr_q;
  assign wdata        = accept ? put_count(fr_word, words_new - CNT_W'(1)) : fr_word;
  assign commit       = body && (left_q == CNT_W'(1));
  assign commit_words = tot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      left_q <= '0;
      tot_q  <= '0;
    end else if (flush) begin
      busy_q <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      ptr_q  <= head_w + AW'(1);
      left_q <= words_new - CNT_W'(1);
      tot_q  <= words_new;
    end else if (ovr_evt) begin
      busy_q <= 1'b0;
    end else if (body) begin
      ptr_q  <= ptr_q + AW'(1);
      left_q <= left_q - CNT_W'(1);
      if (left_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  // R3
  drop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> !busy_q);
endmodule

// File: rtl/canrx_word_fifo.sv
module canrx_word_fifo
  import canrx_pkg::*;
#(
  parameter int BUF_BYTES = 256,
  parameter int CTR_W     = 16,
  localparam int DEPTH    = BUF_BYTES / 4,
  localparam int AW       = $clog2(DEPTH),
  localparam int LW       = $clog2(DEPTH + 1),
  localparam int PW       = AW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fr_vld,
  input  logic             fr_sof,
  input  logic [31:0]      fr_word,
  input  logic             rd_req,
  output logic [31:0]      rd_data,
  input  logic             cmd_flush,
  input  logic             cmd_clr_ovr,
  output logic             empty,
  output logic             full,
  output logic             overrun,
  output logic [LW-1:0]    free_words,
  output logic [LW-1:0]    size_words,
  output logic [PW-1:0]    rd_ptr,
  output logic [PW-1:0]    wr_ptr,
  output logic [LW-1:0]    frame_cnt,
  output logic [CTR_W-1:0] rx_frame_ctr,
  output logic             rx_irq,
  output logic             ovr_irq
);
  logic [AW-1:0]    rd_w_q, head_w, waddr;
  logic [LW-1:0]    level_q, level_nx, frames_q;
  logic [CNT_W-1:0] rem_q, rem_nx, commit_words;
  logic [31:0]      ram_q, wdata;
  logic             wen, commit, ovr_evt, has_data, pop, eof;
  logic             ovr_q, rx_irq_q, ovr_irq_q;
  logic [CTR_W-1:0] ctr_q;

  assign head_w = rd_w_q + level_q[AW-1:0];

  canrx_frame_writer #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) writer_i (
    .clk(clk), .rst_n(rst_n), .flush(cmd_flush),
    .fr_vld(fr_vld), .fr_sof(fr_sof), .fr_word(fr_word),
    .head_w(head_w), .level_w(level_q),
    .wen(wen), .waddr(waddr), .wdata(wdata),
    .commit(commit), .commit_words(commit_words), .ovr_evt(ovr_evt)
  );

  canrx_word_ram #(.DEPTH(DEPTH), .AW(AW)) ram_i (
    .clk(clk), .wen(wen), .waddr(waddr), .wdata(wdata),
    .raddr(rd_w_q), .rdata(ram_q)
  );

  // read side: pop one word, track frame ends from the stored word count
  assign has_data = level_q != '0;
  assign pop      = rd_req && has_data && !cmd_flush;
  assign rd_data  = has_data ? ram_q : '0;
  assign rem_nx   = (rem_q == '0) ? get_count(ram_q) : rem_q - CNT_W'(1);
  assign eof      = pop && (rem_nx == '0);
  assign level_nx = level_q + (commit ? LW'(commit_words) : '0) - (pop ? LW'(1) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_w_q    <= '0;
      level_q   <= '0;
      rem_q     <= '0;
      frames_q  <= '0;
      ctr_q     <= '0;
      ovr_q     <= 1'b0;
      rx_irq_q  <= 1'b0;
      ovr_irq_q <= 1'b0;
    end else begin
      rx_irq_q  <= commit;
      ovr_irq_q <= ovr_evt;
      if (commit) ctr_q <= ctr_q + CTR_W'(1);
      if (ovr_evt)          ovr_q <= 1'b1;
      else if (cmd_clr_ovr) ovr_q <= 1'b0;
      if (cmd_flush) begin
        rd_w_q   <= '0;
        level_q  <= '0;
        rem_q    <= '0;
        frames_q <= '0;
      end else begin
        level_q  <= level_nx;
        frames_q <= frames_q + (commit ? LW'(1) : '0) - (eof ? LW'(1) : '0);
        if (pop) begin
          rd_w_q <= rd_w_q + AW'(1);
          rem_q  <= rem_nx;
        end
      end
    end
  end

  assign empty        = frames_q == '0;
  assign full         = level_q == LW'(DEPTH);
  assign overrun      = ovr_q;
  assign free_words   = LW'(DEPTH) - level_q;
  assign size_words   = LW'(DEPTH);
  assign rd_ptr       = {rd_w_q, 2'b00};
  assign wr_ptr       = {head_w, 2'b00};
  assign frame_cnt    = frames_q;
  assign rx_frame_ctr = ctr_q;
  assign rx_irq       = rx_irq_q;
  assign ovr_irq      = ovr_irq_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(DEPTH));
  // R7
  level_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frames_q == '0) |-> (level_q == '0));
  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> rd_w_q == $past(rd_w_q) + AW'(1));
  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !has_data && !cmd_flush) |=> $stable(rd_w_q));
  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_flush |=> (level_q == '0) && (frames_q == '0) && (rd_w_q == '0));
  // R3
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> overrun && ovr_irq);
endmodule

// File: tb/canrx_word_fifo_tb.sv
`timescale 1ns/1ps
module canrx_word_fifo_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fr_vld = 0, fr_sof = 0, rd_req = 0, cmd_flush = 0, cmd_clr_ovr = 0;
  logic [31:0] fr_word = '0, rd_data;
  logic empty, full, overrun, rx_irq, ovr_irq;
  logic [6:0] free_words, size_words, frame_cnt;
  logic [7:0] rd_ptr, wr_ptr;
  logic [15:0] rx_frame_ctr;

  always #4 clk = ~clk;

  canrx_word_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .fr_vld(fr_vld), .fr_sof(fr_sof), .fr_word(fr_word),
    .rd_req(rd_req), .rd_data(rd_data), .cmd_flush(cmd_flush), .cmd_clr_ovr(cmd_clr_ovr),
    .empty(empty), .full(full), .overrun(overrun), .free_words(free_words),
    .size_words(size_words), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .frame_cnt(frame_cnt),
    .rx_frame_ctr(rx_frame_ctr), .rx_irq(rx_irq), .ovr_irq(ovr_irq)
  );

  int n_chk = 0, n_bad = 0;
  int n_rx = 0, n_ovr = 0;
  // bench model
  logic [31:0] exp_q[$];
  int lens_q[$];
  int m_lvl = 0, m_frames = 0, m_rem = 0, m_rd = 0, m_ctr = 0, m_rx = 0, m_ovr = 0;
  logic m_overrun = 0;

  always @(posedge clk) if (rst_n) begin
    if (rx_irq) n_rx++;
    if (ovr_irq) n_ovr++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bytes_of(input int dlc);
    int t[16] = '{0,1,2,3,4,5,6,7,8,12,16,20,24,32,48,64};
    return t[dlc];
  endfunction

  function automatic int words_of(input int dlc);
    return 4 + (bytes_of(dlc) + 3) / 4;
  endfunction

  task automatic check_status(input string tag);
    chk({tag, " R9 free"}, 32'(free_words), 32'(64 - m_lvl));
    chk({tag, " R9 size"}, 32'(size_words), 32'd64);
    chk({tag, " R5 rd_ptr"}, 32'(rd_ptr), 32'(m_rd));
    chk({tag, " R9 wr_ptr"}, 32'(wr_ptr), 32'((m_rd + 4 * m_lvl) % 256));
    chk({tag, " R7 frame_cnt"}, 32'(frame_cnt), 32'(m_frames));
    chk({tag, " R8 empty"}, 32'(empty), 32'(m_frames == 0));
    chk({tag, " R8 full"}, 32'(full), 32'(m_lvl == 64));
    chk({tag, " R4 ctr"}, 32'(rx_frame_ctr), 32'(m_ctr));
    chk({tag, " R11 overrun"}, 32'(overrun), 32'(m_overrun));
    chk({tag, " R4 rx pulses"}, 32'(n_rx), 32'(m_rx));
    chk({tag, " R3 ovr pulses"}, 32'(n_ovr), 32'(m_ovr));
  endtask

  task automatic send_frame(input int dlc, input logic [31:0] tag);
    int nw = words_of(dlc);
    bit fits = (m_lvl + nw) <= 64;
    for (int i = 0; i < nw; i++) begin
      logic [31:0] w;
      @(negedge clk);
      if (i == 1) chk("R3 ovr_irq timing", 32'(ovr_irq), 32'(!fits));
      w = (i == 0) ? ((tag & 32'hFFFF_FFF0) | 32'(dlc)) : (tag ^ (32'(i) * 32'h0101_0101));
      fr_vld = 1; fr_sof = (i == 0); fr_word = w;
      if (fits) exp_q.push_back(i == 0 ? ((w & ~32'h0000_F800) | (32'(nw - 1) << 11)) : w);
    end
    @(negedge clk);
    fr_vld = 0; fr_sof = 0;
    chk("R4 rx_irq timing", 32'(rx_irq), 32'(fits));
    if (fits) begin
      lens_q.push_back(nw); m_lvl += nw; m_frames++; m_ctr++; m_rx++;
    end else begin
      m_overrun = 1; m_ovr++;
    end
    @(negedge clk);
    chk("R4 rx_irq width", 32'(rx_irq), 32'd0);
  endtask

  task automatic pop1(input string tag);
    logic [31:0] e;
    bit had = m_lvl != 0;
    @(negedge clk);
    rd_req = 1; #1;
    e = had ? exp_q.pop_front() : 32'd0;
    chk({tag, had ? " R2/R5 data" : " R6 empty data"}, rd_data, e);
    @(negedge clk);
    rd_req = 0;
    if (had) begin
      m_rd = (m_rd + 4) % 256; m_lvl--;
      if (m_rem == 0) m_rem = lens_q[0];
      m_rem--;
      if (m_rem == 0) begin void'(lens_q.pop_front()); m_frames--; end
    end
    chk({tag, " R7 frame_cnt"}, 32'(frame_cnt), 32'(m_frames));
    chk({tag, " R5 rd_ptr"}, 32'(rd_ptr), 32'(m_rd));
  endtask

  task automatic do_flush();
    @(negedge clk); cmd_flush = 1;
    @(negedge clk); cmd_flush = 0;
    exp_q.delete(); lens_q.delete();
    m_lvl = 0; m_frames = 0; m_rem = 0; m_rd = 0;
  endtask

  task automatic t_reset();
    check_status("reset");
    chk("R6 reset rd_data", rd_data, 32'd0);
  endtask

  task automatic t_single();
    send_frame(8, 32'hA5C3_7F18);
    check_status("single R1");
    for (int k = 0; k < 6; k++) pop1("single");
    check_status("single drained");
  endtask

  task automatic t_sizes();
    send_frame(13, 32'h1234_5678);
    send_frame(9, 32'hCAFE_0F00);
    send_frame(0, 32'h0BAD_F00D);
    check_status("sizes R1");
    for (int k = 0; k < 23; k++) pop1("sizes");
    check_status("sizes drained");
  endtask

  task automatic t_empty_read();
    pop1("empty");
    pop1("empty again");
    check_status("empty R6");
  endtask

  task automatic t_overrun();
    send_frame(15, 32'h1111_2222);
    send_frame(15, 32'h3333_4444);
    send_frame(15, 32'h5555_6666);
    check_status("fill");
    send_frame(15, 32'h7777_8888);  // R3 drop
    check_status("drop R3");
    send_frame(0, 32'h9999_AAA0);
    check_status("full R8");
    @(negedge clk); fr_vld = 1; fr_sof = 0; fr_word = 32'hDEAD_BEEF;
    @(negedge clk); fr_vld = 0;
    check_status("stray R12");
  endtask

  task automatic t_clear_ovr();
    @(negedge clk); fr_vld = 1; fr_sof = 1; fr_word = 32'h0000_0000; cmd_clr_ovr = 1;
    @(negedge clk); fr_vld = 0; fr_sof = 0; cmd_clr_ovr = 0;
    m_ovr++;
    @(negedge clk);
    check_status("set beats clear R11");
    @(negedge clk); cmd_clr_ovr = 1;
    @(negedge clk); cmd_clr_ovr = 0;
    m_overrun = 0;
    check_status("clear R11");
  endtask

  task automatic t_drain_all();
    for (int k = 0; k < 64; k++) pop1("drain R5");
    check_status("drained");
    pop1("after drain R6");
  endtask

  task automatic t_flush();
    send_frame(2, 32'h4242_4240);
    pop1("pre-flush");
    pop1("pre-flush");
    do_flush();
    check_status("flush R10");
    // partial frame abandoned by flush
    @(negedge clk); fr_vld = 1; fr_sof = 1; fr_word = 32'h0000_0008;
    @(negedge clk); fr_word = 32'h0000_0111;
    @(negedge clk); fr_vld = 0;
    do_flush();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); fr_vld = 1; fr_sof = 0; fr_word = 32'(i);
    end
    @(negedge clk); fr_vld = 0;
    check_status("abandon R10 R12");
    send_frame(1, 32'h7E7E_0000);
    for (int k = 0; k < 5; k++) pop1("post-flush R10");
    check_status("post-flush");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_sizes();
    t_empty_read();
    t_overrun();
    t_clear_ovr();
    t_drain_all();
    t_flush();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule